// File: doc/BRIEF.md
# Two-Bit Hardware Cursor Overlay

This block lays a 64x64 hardware cursor over a stream of display pixels. Each cursor pixel is a 2-bit code held in a local map, loaded through a simple write port. For every incoming pixel the block uses the beam coordinates to decide whether that pixel falls inside the cursor window. It then emits one of four things: the underlying pixel, the foreground color index, the background color index, or the bitwise inverse of the underlying pixel.

The cursor origin has two parts. A coarse position is aligned down to a multiple of 8. Signed-free 16-bit X and Y offsets are added to it. The window can skip the leftmost columns of the map, starting at a programmable first column, and can be cut short to a programmed number of lines. The overlay decision is registered, so every output pixel leaves exactly one clock after it entered, together with its coordinates.

Top module: `cursor_overlay`

## Requirements
- R1: While reset is asserted, and until the first valid pixel after it, out_valid, pix_out, out_x and out_y are all zero.
- R2: A pixel presented with pix_valid high appears on the outputs one clock later with out_valid high and out_x/out_y equal to the presented pix_x/pix_y.
- R3: When cur_ctrl bit 15 is clear, pix_out equals the presented pixel whatever the map and the other cur_ctrl bits hold.
- R4: Inside the window the map code selects the output: 00 gives cur_color[15:8] (background), 01 gives cur_color[7:0] (foreground), 10 gives the presented pixel, 11 gives its bitwise inverse.
- R5: The window origin is base with its low three bits cleared, plus the offset, modulo 2^16, separately for X and Y. A beam position that wraps past 0xFFFF is still inside the window.
- R6: Columns first_col through 63 of the map are shown. The beam at X = origin_x + k, for 0 <= k < 64 - first_col, reads map column first_col + k. The beam at origin_x + 64 - first_col or beyond, and the beam left of the origin, pass the pixel through.
- R7: Map rows 0 through line_cnt - 1 are shown at Y = origin_y + row. A line_cnt of 0 shows no cursor.
- R8: A map write stores map_wdata at row map_addr[11:6] and column map_addr[5:0]. It applies to pixels presented on later cycles.
- R9: When pix_valid is low, out_valid is low one clock later and pix_out, out_x and out_y hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| map_we | input | 1 | Cursor map write strobe |
| map_addr | input | 12 | Map address: row in [11:6], column in [5:0] |
| map_wdata | input | 2 | Cursor code to store |
| cur_ctrl | input | 16 | Control word, bit 15 enables the cursor |
| base_x | input | 16 | Coarse cursor X (low three bits ignored) |
| base_y | input | 16 | Coarse cursor Y (low three bits ignored) |
| off_x | input | 16 | X offset added to the coarse X |
| off_y | input | 16 | Y offset added to the coarse Y |
| first_col | input | 6 | First map column shown |
| line_cnt | input | 6 | Number of map rows shown |
| cur_color | input | 16 | Foreground index [7:0], background index [15:8] |
| pix_valid | input | 1 | Input pixel qualifier |
| pix_x | input | 16 | Beam X of the input pixel |
| pix_y | input | 16 | Beam Y of the input pixel |
| pix_in | input | 8 | Underlying pixel index |
| out_valid | output | 1 | Output pixel qualifier |
| out_x | output | 16 | Beam X of the output pixel |
| out_y | output | 16 | Beam Y of the output pixel |
| pix_out | output | 8 | Overlaid pixel index |

## Verification
Every internal fault surfaces on pix_out one clock after the affected pixel enters. A corrupted map cell shows as a wrong color at exactly that beam position. A mistaken origin, column start or line count moves a window edge by one or more pixels, so the bench probes the pixels on both sides of every edge. A miscomputed map column shows as a shifted cursor pattern, which a map filled with a position-dependent pattern exposes at once.

// File: rtl/cursor_overlay.sv
module cursor_overlay #(
  parameter int CW      = 16,
  parameter int PW      = 8,
  parameter int MAP_LOG = 6,
  parameter int EN_BIT  = 15
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 map_we,
  input  logic [2*MAP_LOG-1:0] map_addr,
  input  logic [1:0]           map_wdata,
  input  logic [15:0]          cur_ctrl,
  input  logic [CW-1:0]        base_x,
  input  logic [CW-1:0]        base_y,
  input  logic [CW-1:0]        off_x,
  input  logic [CW-1:0]        off_y,
  input  logic [MAP_LOG-1:0]   first_col,
  input  logic [MAP_LOG-1:0]   line_cnt,
  input  logic [2*PW-1:0]      cur_color,
  input  logic                 pix_valid,
  input  logic [CW-1:0]        pix_x,
  input  logic [CW-1:0]        pix_y,
  input  logic [PW-1:0]        pix_in,
  output logic                 out_valid,
  output logic [CW-1:0]        out_x,
  output logic [CW-1:0]        out_y,
  output logic [PW-1:0]        pix_out
);
  localparam int DIM   = 1 << MAP_LOG;
  localparam int ROW_W = 2 * DIM;
  localparam int ALIGN = 3;

  logic [ROW_W-1:0]   map_rows [DIM];
  logic [CW-1:0]      org_x, org_y, dx, dy;
  logic [MAP_LOG:0]   vis_cols;
  logic [MAP_LOG-1:0] rd_col, rd_row, wr_row, wr_col;
  logic [ROW_W-1:0]   row_bits;
  logic [1:0]         code;
  logic               in_x, in_y, hit;
  logic [PW-1:0]      sel_pix, next_pix;
  logic               unused_bits;

  assign unused_bits = ^{cur_ctrl, base_x[ALIGN-1:0], base_y[ALIGN-1:0]};

  assign wr_row = map_addr[2*MAP_LOG-1:MAP_LOG];
  assign wr_col = map_addr[MAP_LOG-1:0];

  always_ff @(posedge clk)
    if (map_we) map_rows[wr_row][{wr_col, 1'b0} +: 2] <= map_wdata;

  assign org_x = {base_x[CW-1:ALIGN], {ALIGN{1'b0}}} + off_x;
  assign org_y = {base_y[CW-1:ALIGN], {ALIGN{1'b0}}} + off_y;
  assign dx    = pix_x - org_x;
  assign dy    = pix_y - org_y;

  assign vis_cols = (MAP_LOG+1)'(DIM) - {1'b0, first_col};
  assign in_x     = dx < CW'(vis_cols);
  assign in_y     = dy < CW'(line_cnt);
  assign hit      = cur_ctrl[EN_BIT] & in_x & in_y;

  assign rd_col   = first_col + dx[MAP_LOG-1:0];
  assign rd_row   = dy[MAP_LOG-1:0];
  assign row_bits = map_rows[rd_row];
  assign code     = row_bits[{rd_col, 1'b0} +: 2];

  always_comb begin
    unique case (code)
      2'b00:   sel_pix = cur_color[2*PW-1:PW];
      2'b01:   sel_pix = cur_color[PW-1:0];
      2'b10:   sel_pix = pix_in;
      default: sel_pix = ~pix_in;
    endcase
  end

  assign next_pix = hit ? sel_pix : pix_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_x     <= '0;
      out_y     <= '0;
      pix_out   <= '0;
    end else begin
      out_valid <= pix_valid;
      if (pix_valid) begin
        out_x   <= pix_x;
        out_y   <= pix_y;
        pix_out <= next_pix;
      end
    end
  end
endmodule

// File: rtl/cursor_overlay_chk.sv
module cursor_overlay_chk #(
  parameter int CW = 16,
  parameter int PW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [15:0]     cur_ctrl,
  input logic [5:0]      line_cnt,
  input logic [2*PW-1:0] cur_color,
  input logic            pix_valid,
  input logic [CW-1:0]   pix_x,
  input logic [CW-1:0]   pix_y,
  input logic [PW-1:0]   pix_in,
  input logic            out_valid,
  input logic [CW-1:0]   out_x,
  input logic [CW-1:0]   out_y,
  input logic [PW-1:0]   pix_out
);
  assert_reset_zero_R1: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && pix_out == '0 && out_x == '0 && out_y == '0));

  assert_one_clock_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> (out_valid && out_x == $past(pix_x) && out_y == $past(pix_y)));

  assert_disabled_passes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !cur_ctrl[15]) |=> pix_out == $past(pix_in));

  assert_legal_choice_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> (pix_out == $past(pix_in) || pix_out == ~$past(pix_in) ||
                   pix_out == $past(cur_color[PW-1:0]) ||
                   pix_out == $past(cur_color[2*PW-1:PW])));

  assert_zero_lines_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && line_cnt == 6'd0) |=> pix_out == $past(pix_in));

  assert_idle_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> (!out_valid && $stable(pix_out) && $stable(out_x) && $stable(out_y)));
endmodule

bind cursor_overlay cursor_overlay_chk #(.CW(CW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cur_ctrl(cur_ctrl), .line_cnt(line_cnt),
  .cur_color(cur_color), .pix_valid(pix_valid), .pix_x(pix_x), .pix_y(pix_y),
  .pix_in(pix_in), .out_valid(out_valid), .out_x(out_x), .out_y(out_y),
  .pix_out(pix_out)
);

// File: tb/tb_cursor_overlay.sv
`timescale 1ns/1ps
module tb_cursor_overlay;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        map_we = 1'b0;
  logic [11:0] map_addr = '0;
  logic [1:0]  map_wdata = '0;
  logic [15:0] cur_ctrl = '0;
  logic [15:0] base_x = '0, base_y = '0, off_x = '0, off_y = '0;
  logic [5:0]  first_col = '0, line_cnt = '0;
  logic [15:0] cur_color = '0;
  logic        pix_valid = 1'b0;
  logic [15:0] pix_x = '0, pix_y = '0;
  logic [7:0]  pix_in = '0;
  logic        out_valid;
  logic [15:0] out_x, out_y;
  logic [7:0]  pix_out;

  always #2.5 clk = ~clk;

  cursor_overlay dut (
    .clk(clk), .rst_n(rst_n), .map_we(map_we), .map_addr(map_addr),
    .map_wdata(map_wdata), .cur_ctrl(cur_ctrl), .base_x(base_x), .base_y(base_y),
    .off_x(off_x), .off_y(off_y), .first_col(first_col), .line_cnt(line_cnt),
    .cur_color(cur_color), .pix_valid(pix_valid), .pix_x(pix_x), .pix_y(pix_y),
    .pix_in(pix_in), .out_valid(out_valid), .out_x(out_x), .out_y(out_y),
    .pix_out(pix_out)
  );

  typedef struct {
    logic [15:0] x;
    logic [15:0] y;
    logic [7:0]  p;
    string       tag;
  } item_t;

  item_t       sb[$];
  logic [127:0] bmap [64];
  int          n_vec = 0;
  int          n_bad = 0;
  logic [7:0]  last_pix = '0;
  logic [15:0] last_x = '0, last_y = '0;

  function automatic logic [7:0] model(input logic [15:0] x, input logic [15:0] y,
                                       input logic [7:0] p);
    logic [15:0] ox, oy, kx, ky;
    logic [5:0]  col;
    logic [1:0]  c;
    if (!cur_ctrl[15]) return p;
    ox = (base_x & 16'hFFF8) + off_x;
    oy = (base_y & 16'hFFF8) + off_y;
    kx = x - ox;
    ky = y - oy;
    if (kx >= 16'(64 - int'(first_col)) || ky >= 16'(line_cnt)) return p;
    col = first_col + kx[5:0];
    c = bmap[ky[5:0]][int'(col)*2 +: 2];
    case (c)
      2'b00:   return cur_color[15:8];
      2'b01:   return cur_color[7:0];
      2'b10:   return p;
      default: return ~p;
    endcase
  endfunction

  task automatic push(input logic [15:0] x, input logic [15:0] y,
                      input logic [7:0] p, input string tag);
    item_t it;
    @(negedge clk);
    pix_valid = 1'b1;
    pix_x = x;
    pix_y = y;
    pix_in = p;
    it.x = x; it.y = y; it.p = model(x, y, p); it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    pix_valid = 1'b0;
  endtask

  task automatic wr(input int r, input int c, input logic [1:0] d);
    @(negedge clk);
    pix_valid = 1'b0;
    map_we = 1'b1;
    map_addr = {6'(r), 6'(c)};
    map_wdata = d;
    bmap[r][c*2 +: 2] = d;
    @(negedge clk);
    map_we = 1'b0;
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      if (out_valid) begin
        if (sb.size() == 0) begin
          n_vec++; n_bad++;
          $display("FAIL R2: unexpected output x=%0h y=%0h pix=%0h, expected none",
                   out_x, out_y, pix_out);
        end else begin
          item_t e;
          e = sb.pop_front();
          n_vec++;
          if (out_x !== e.x || out_y !== e.y || pix_out !== e.p) begin
            n_bad++;
            $display("FAIL %s: got x=%0h y=%0h pix=%0h, expected x=%0h y=%0h pix=%0h",
                     e.tag, out_x, out_y, pix_out, e.x, e.y, e.p);
          end
        end
      end else begin
        n_vec++;
        if (pix_out !== last_pix || out_x !== last_x || out_y !== last_y) begin
          n_bad++;
          $display("FAIL R9: idle output pix=%0h x=%0h y=%0h, expected held pix=%0h x=%0h y=%0h",
                   pix_out, out_x, out_y, last_pix, last_x, last_y);
        end
      end
      last_pix = pix_out;
      last_x = out_x;
      last_y = out_y;
    end
  end

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] ox, oy;
    repeat (3) @(negedge clk);
    n_vec++;
    if (out_valid !== 1'b0 || pix_out !== 8'h00 || out_x !== 16'h0 || out_y !== 16'h0) begin
      n_bad++;
      $display("FAIL R1: reset outputs valid=%0b pix=%0h x=%0h y=%0h, expected all zero",
               out_valid, pix_out, out_x, out_y);
    end
    rst_n = 1'b1;

    // R8: fill the map with a position-dependent pattern
    for (int r = 0; r < 64; r++)
      for (int c = 0; c < 64; c++) begin
        @(negedge clk);
        map_we = 1'b1;
        map_addr = {6'(r), 6'(c)};
        map_wdata = 2'((r + 3 * c + (r >> 2)) & 3);
        bmap[r][c*2 +: 2] = map_wdata;
      end
    @(negedge clk);
    map_we = 1'b0;

    // R3: disabled cursor, other control bits set
    cur_ctrl = 16'h7FFF;
    base_x = 16'h0105; off_x = 16'd3;
    base_y = 16'h0047; off_y = 16'd2;
    first_col = 6'd0; line_cnt = 6'd63;
    cur_color = 16'hA55A;
    ox = 16'h0103; oy = 16'h0042;
    for (int k = 0; k < 8; k++) push(ox + 16'(k), oy + 16'(k), 8'(8'h30 + k), "R3");
    idle();

    // R4/R5/R6/R7: enabled, edges of the window
    cur_ctrl = 16'h8000;
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++) begin
        logic [15:0] xs [4];
        logic [15:0] ys [4];
        xs = '{ox - 16'd1, ox, ox + 16'd63, ox + 16'd64};
        ys = '{oy - 16'd1, oy, oy + 16'd62, oy + 16'd63};
        push(xs[i], ys[j], 8'(8'h5C + i * 4 + j), (i == 0 || i == 3) ? "R6" : ((j == 0 || j == 3) ? "R7" : "R5"));
      end
    for (int k = 0; k < 64; k++) push(ox + 16'(k), oy + 16'(k % 63), 8'(k * 7), "R4");
    idle();
    idle();

    // R6: start column 60 gives four visible columns
    first_col = 6'd60;
    for (int k = -1; k < 6; k++) push(ox + 16'(k), oy + 16'd5, 8'hC3, "R6");
    idle();

    // R7: zero lines hides the cursor
    first_col = 6'd0; line_cnt = 6'd0;
    for (int k = 0; k < 6; k++) push(ox + 16'(k), oy, 8'h11, "R7");
    idle();
    line_cnt = 6'd1;
    push(ox + 16'd2, oy, 8'h22, "R7");
    push(ox + 16'd2, oy + 16'd1, 8'h22, "R7");
    idle();

    // R5: origin wraps past 0xFFFF
    base_x = 16'hFFFF; off_x = 16'd4;
    base_y = 16'hFFF9; off_y = 16'd6;
    line_cnt = 6'd20;
    for (int k = 0; k < 10; k++) push(16'hFFFA + 16'(k), 16'h0002, 8'(8'h90 + k), "R5");
    idle();

    // R4/R8: rewrite one cell with each code
    base_x = 16'h0200; off_x = 16'd0;
    base_y = 16'h0100; off_y = 16'd0;
    line_cnt = 6'd63; first_col = 6'd0;
    cur_color = 16'h3CE1;
    for (int c = 0; c < 4; c++) begin
      wr(40, 33, 2'(c));
      push(16'h0200 + 16'd33, 16'h0100 + 16'd40, 8'h6B, "R8");
      push(16'h0200 + 16'd32, 16'h0100 + 16'd40, 8'h6B, "R4");
    end
    idle();

    // R2/R9: alternating gaps
    for (int k = 0; k < 8; k++) begin
      push(16'h0200 + 16'(k * 5), 16'h0100 + 16'(k), 8'(k * 29), "R2");
      idle();
    end

    repeat (4) @(negedge clk);
    n_vec++;
    if (sb.size() != 0) begin
      n_bad++;
      $display("FAIL R2: %0d pixels never emerged, expected 0", sb.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule